// File: doc/BRIEF.md
# Quadrant Pixel Output Router

This block decides, pixel by pixel, which of eight output buses carries the data of one readout quadrant. The pixel stream arrives one word per accepted clock. A line-start marker tags column zero, and the block counts the columns that follow by itself. The quadrant is 1024 columns wide, and the columns are split into eight groups of 128 consecutive columns. Each accepted pixel appears one clock later on exactly one bus, with a valid bit. The bus number and the column number are reported beside it.

Two mode inputs pick the routing:

- Everything on bus 0.
- Each column group fixed to its own bus.
- A rotating assignment that moves every group to the next bus at each frame start.

A rotation-release input holds the rotating pattern at its initial, unrotated state while it is low. The column after the last real one is the overclocked reference pixel. It raises a flag and drives no bus. The reserved mode combination falls back to single-bus routing and latches an error flag.

Top module: `quad_bus_router`

## Requirements
- R1: While reset is low and on the first sample after it, all bus valid bits, all bus data, bus_idx, col_out, ref_flag and mode_err are zero, and the rotation offset is zero.
- R2: With mode_a=1, mode_b=0, every pixel of columns 0 to 1023 appears on bus 0 (data bits [DW-1:0], valid bit 0) and bus_idx reads 0.
- R3: With mode_a=0, mode_b=0, a pixel of column c appears on bus c/128 (data bits [b*DW +: DW], valid bit b) and bus_idx equals that bus.
- R4: With mode_a=0, mode_b=1, a pixel of column c appears on bus (c/128 + offset) mod 8, where offset is the current rotation offset.
- R5: While lrst_n is high, each clock with frame_start high advances the offset by one, wrapping from 7 to 0. Without frame_start the offset holds. A pixel in the cycle after the pulse already uses the new offset.
- R6: While lrst_n is low, the offset is forced to 0 at every clock and frame_start has no effect, so rotating mode routes exactly like R3.
- R7: A pixel accepted with line_start high is column 0. Each later accepted pixel is the previous column plus one, and clocks with pix_valid low do not advance the count. col_out reports the column of the routed pixel.
- R8: The 1025th pixel of a line (column 1024) raises ref_flag for one pixel time, with col_out = 1024 and no bus valid. Pixels after it raise nothing.
- R9: Buses not selected for the current pixel carry zero data with their valid bit low. At most one valid bit is high at a time.
- R10: With mode_a=1, mode_b=1, routing is identical to R2, and mode_err rises one clock later and stays high until reset.
- R11: Every routed result appears exactly one clock after the edge that accepts the pixel, and a clock with no pixel leaves all valid bits, data and ref_flag zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_a | input | 1 | Mode select bit, high selects single-bus routing |
| mode_b | input | 1 | Mode select bit, high with mode_a low selects rotating routing |
| lrst_n | input | 1 | Rotation release; low holds the offset at zero |
| frame_start | input | 1 | One-clock frame marker that advances the rotation |
| line_start | input | 1 | Marks the accepted pixel as column 0 |
| pix_valid | input | 1 | A pixel is present this clock |
| pix_data | input | DW | Pixel data word |
| bus_data | output | NBUS*DW | Routed data, bus b in bits [b*DW +: DW] |
| bus_vld | output | NBUS | Per-bus valid bits |
| bus_idx | output | $clog2(NBUS) | Bus number of the routed pixel |
| col_out | output | $clog2(COLS+2) | Column of the routed or reference pixel |
| ref_flag | output | 1 | Reference pixel marker |
| mode_err | output | 1 | Sticky reserved-mode flag |

## Verification
Routing, column number and the reference flag are registered once, so each result is due at the clock edge after the one that accepts the pixel. The bench drives a pixel at a falling edge and compares the outputs at the next falling edge, before it drives the next pixel. A frame_start pulse changes the offset at the following edge, so the bench issues it in a cycle of its own and starts a line only after that. mode_err is due one edge after the reserved combination is applied. It is sampled after a full line in that mode, and again after the mode has been changed back.

// File: rtl/qbr_pkg.sv
package qbr_pkg;

  typedef enum logic [1:0] {
    MODE_SPREAD = 2'b00,
    MODE_ROTATE = 2'b01,
    MODE_SINGLE = 2'b10,
    MODE_RESV   = 2'b11
  } route_mode_e;

  // Bus chosen for a column: group number, plus offset when rotating.
  function automatic int unsigned lane_for(route_mode_e m, int unsigned col,
                                           int unsigned off, int unsigned grp_lg,
                                           int unsigned nbus);
    int unsigned grp;
    grp = col >> grp_lg;
    case (m)
      MODE_SPREAD: return grp & (nbus - 1);
      MODE_ROTATE: return (grp + off) & (nbus - 1);
      default:     return 0;
    endcase
  endfunction

  function automatic logic is_reserved(logic a, logic b);
    return a & b;
  endfunction

endpackage

// File: rtl/qbr_col_counter.sv
module qbr_col_counter #(
  parameter int COLS = 1024,
  parameter int CW   = $clog2(COLS + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          line_start,
  output logic [CW-1:0] cur_col,
  output logic          in_active,
  output logic          is_ref
);
  localparam logic [CW-1:0] LAST_REAL = CW'(COLS);
  localparam logic [CW-1:0] PARKED    = CW'(COLS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] nxt;

  assign cur_col   = line_start ? '0 : cnt_q;
  assign nxt       = (cur_col >= PARKED) ? PARKED : cur_col + 1'b1;
  assign in_active = pix_valid && (cur_col < LAST_REAL);
  assign is_ref    = pix_valid && (cur_col == LAST_REAL);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= PARKED;
    else if (pix_valid) cnt_q <= nxt;
  end
endmodule

// File: rtl/qbr_rotator.sv
module qbr_rotator #(
  parameter int NBUS = 8,
  parameter int BW   = $clog2(NBUS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          lrst_n,
  output logic [BW-1:0] offset
);
  logic [BW-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !lrst_n) off_q <= '0;
    else if (frame_start)  off_q <= off_q + 1'b1;
  end

  assign offset = off_q;
endmodule

// File: rtl/qbr_mode_decode.sv
module qbr_mode_decode
  import qbr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_a,
  input  logic        mode_b,
  output route_mode_e mode,
  output logic        err_sticky
);
  logic err_q;

  assign mode = route_mode_e'({mode_a, mode_b});

  always_ff @(posedge clk) begin
    if (!rst_n)                          err_q <= 1'b0;
    else if (is_reserved(mode_a, mode_b)) err_q <= 1'b1;
  end

  assign err_sticky = err_q;
endmodule

// File: rtl/qbr_out_stage.sv
module qbr_out_stage #(
  parameter int NBUS = 8,
  parameter int DW   = 16,
  parameter int BW   = $clog2(NBUS),
  parameter int CW   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_active,
  input  logic               is_ref,
  input  logic [BW-1:0]      lane,
  input  logic [CW-1:0]      cur_col,
  input  logic [DW-1:0]      pix_data,
  output logic [NBUS*DW-1:0] bus_data,
  output logic [NBUS-1:0]    bus_vld,
  output logic [BW-1:0]      bus_idx,
  output logic [CW-1:0]      col_out,
  output logic               ref_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_data <= '0;
      bus_vld  <= '0;
      bus_idx  <= '0;
      col_out  <= '0;
      ref_flag <= 1'b0;
    end else begin
      for (int g = 0; g < NBUS; g++) begin
        bus_data[g*DW +: DW] <= (in_active && lane == BW'(g)) ? pix_data : '0;
        bus_vld[g]           <= in_active && lane == BW'(g);
      end
      bus_idx  <= in_active ? lane : '0;
      col_out  <= (in_active || is_ref) ? cur_col : '0;
      ref_flag <= is_ref;
    end
  end
endmodule

// File: rtl/quad_bus_router.sv
module quad_bus_router
  import qbr_pkg::*;
#(
  parameter int COLS = 1024,
  parameter int NBUS = 8,
  parameter int DW   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_a,
  input  logic                     mode_b,
  input  logic                     lrst_n,
  input  logic                     frame_start,
  input  logic                     line_start,
  input  logic                     pix_valid,
  input  logic [DW-1:0]            pix_data,
  output logic [NBUS*DW-1:0]       bus_data,
  output logic [NBUS-1:0]          bus_vld,
  output logic [$clog2(NBUS)-1:0]  bus_idx,
  output logic [$clog2(COLS+2)-1:0] col_out,
  output logic                     ref_flag,
  output logic                     mode_err
);
  localparam int BW     = $clog2(NBUS);
  localparam int CW     = $clog2(COLS + 2);
  localparam int GROUP  = COLS / NBUS;
  localparam int GRP_LG = $clog2(GROUP);

  // Named internal events, visible to the bound checker.
  logic [CW-1:0] cur_col;
  logic          in_active;
  logic          is_ref;
  logic [BW-1:0] rot_off;
  logic [BW-1:0] lane;
  route_mode_e   mode;

  qbr_col_counter #(.COLS(COLS), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_start(line_start),
    .cur_col(cur_col), .in_active(in_active), .is_ref(is_ref)
  );

  qbr_rotator #(.NBUS(NBUS), .BW(BW)) u_rot (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .lrst_n(lrst_n),
    .offset(rot_off)
  );

  qbr_mode_decode u_mode (
    .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
    .mode(mode), .err_sticky(mode_err)
  );

  assign lane = BW'(lane_for(mode, 32'(cur_col), 32'(rot_off), GRP_LG, NBUS));

  qbr_out_stage #(.NBUS(NBUS), .DW(DW), .BW(BW), .CW(CW)) u_out (
    .clk(clk), .rst_n(rst_n), .in_active(in_active), .is_ref(is_ref),
    .lane(lane), .cur_col(cur_col), .pix_data(pix_data),
    .bus_data(bus_data), .bus_vld(bus_vld), .bus_idx(bus_idx),
    .col_out(col_out), .ref_flag(ref_flag)
  );
endmodule

// File: rtl/qbr_checker.sv
module qbr_checker #(
  parameter int NBUS = 8,
  parameter int DW   = 16,
  parameter int BW   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_a,
  input logic               mode_b,
  input logic               lrst_n,
  input logic               frame_start,
  input logic [NBUS*DW-1:0] bus_data,
  input logic [NBUS-1:0]    bus_vld,
  input logic [BW-1:0]      bus_idx,
  input logic               ref_flag,
  input logic               mode_err,
  input logic [BW-1:0]      offset
);
  AST_VLD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_vld)); // R9
  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld != '0) |-> bus_vld[bus_idx]); // R9
  AST_REF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ref_flag |-> (bus_vld == '0)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err); // R10
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a && mode_b) |=> mode_err); // R10
  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_a |=> ((bus_vld >> 1) == '0)); // R2
  AST_LRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lrst_n |=> (offset == '0)); // R6
  AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lrst_n && frame_start) |=> (offset == BW'($past(offset) + 1'b1))); // R5
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lrst_n && !frame_start) |=> $stable(offset)); // R5

  for (genvar g = 0; g < NBUS; g++) begin : g_lane
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_vld[g] |-> (bus_data[g*DW +: DW] == '0)); // R9
  end
endmodule

bind quad_bus_router qbr_checker #(.NBUS(NBUS), .DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
  .lrst_n(lrst_n), .frame_start(frame_start), .bus_data(bus_data),
  .bus_vld(bus_vld), .bus_idx(bus_idx), .ref_flag(ref_flag),
  .mode_err(mode_err), .offset(rot_off)
);

// File: tb/quad_bus_router_tb.sv
`timescale 1ns/1ps
module quad_bus_router_tb;
  localparam int COLS = 1024;
  localparam int NBUS = 8;
  localparam int DW   = 16;
  localparam int BW   = 3;
  localparam int CW   = 11;

  logic clk = 1'b0;
  logic rst_n, mode_a, mode_b, lrst_n, frame_start, line_start, pix_valid;
  logic [DW-1:0]      pix_data;
  logic [NBUS*DW-1:0] bus_data;
  logic [NBUS-1:0]    bus_vld;
  logic [BW-1:0]      bus_idx;
  logic [CW-1:0]      col_out;
  logic               ref_flag, mode_err;

  int checks = 0;
  int fails  = 0;
  int exp_off = 0;
  int seed = 0;
  bit done = 0;

  always #10 clk = ~clk;

  quad_bus_router #(.COLS(COLS), .NBUS(NBUS), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
    .lrst_n(lrst_n), .frame_start(frame_start), .line_start(line_start),
    .pix_valid(pix_valid), .pix_data(pix_data), .bus_data(bus_data),
    .bus_vld(bus_vld), .bus_idx(bus_idx), .col_out(col_out),
    .ref_flag(ref_flag), .mode_err(mode_err)
  );

  function automatic int exp_lane(logic a, logic b, int col, int off);
    if (a) return 0;                    // single and reserved
    if (!b) return col / 128;           // fixed groups
    return (col / 128 + off) % NBUS;    // rotating
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(bus_vld == '0 && bus_data == '0 && ref_flag == 1'b0, req,
          "idle outputs", longint'(bus_vld), 0);
  endtask

  // One full line plus the reference and one extra overclock pixel.
  task automatic run_line(input string req);
    logic [NBUS*DW-1:0] eb;
    logic [DW-1:0] d;
    int ln;
    seed = seed + 13;
    for (int c = 0; c <= COLS + 1; c++) begin
      d = DW'(c * 37 + seed);
      pix_valid = 1'b1; line_start = (c == 0); pix_data = d;
      @(negedge clk);
      if (c < COLS) begin
        ln = exp_lane(mode_a, mode_b, c, exp_off);
        eb = '0; eb[ln*DW +: DW] = d;
        check(bus_data == eb && bus_vld == NBUS'(1 << ln) && bus_idx == BW'(ln)
              && col_out == CW'(c) && !ref_flag, req, $sformatf("col %0d bus", c),
              longint'(bus_vld), longint'(1 << ln));
      end else if (c == COLS) begin
        check(ref_flag && bus_vld == '0 && bus_data == '0 && col_out == CW'(COLS),
              "R8", "reference pixel", longint'({ref_flag, col_out}),
              longint'({1'b1, CW'(COLS)}));
      end else begin
        check(!ref_flag && bus_vld == '0, "R8", "past reference",
              longint'({ref_flag, bus_vld}), 0);
      end
    end
    pix_valid = 1'b0; line_start = 1'b0;
    @(negedge clk);
    check_idle("R11");
  endtask

  task automatic frame_pulse();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    exp_off = lrst_n ? (exp_off + 1) % NBUS : 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode_a = 1'b0; mode_b = 1'b0; lrst_n = 1'b0;
    frame_start = 1'b0; line_start = 1'b0; pix_valid = 1'b0; pix_data = '0;
    repeat (3) @(negedge clk);
    check(bus_vld == '0 && bus_data == '0 && bus_idx == '0 && col_out == '0
          && !ref_flag && !mode_err, "R1", "reset outputs", longint'(bus_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
    exp_off = 0;
  endtask

  task automatic t_single();
    mode_a = 1'b1; mode_b = 1'b0;
    run_line("R2");
  endtask

  task automatic t_spread();
    mode_a = 1'b0; mode_b = 1'b0;
    run_line("R3");
  endtask

  task automatic t_hold();
    mode_a = 1'b0; mode_b = 1'b1; lrst_n = 1'b0;
    @(negedge clk);
    exp_off = 0;
    frame_pulse(); frame_pulse();
    run_line("R6");
  endtask

  task automatic t_rotate();
    mode_a = 1'b0; mode_b = 1'b1; lrst_n = 1'b1;
    @(negedge clk);
    frame_pulse();
    run_line("R4");
    for (int i = 0; i < 6; i++) frame_pulse();
    run_line("R4");                 // offset 7
    frame_pulse();
    run_line("R5");                 // wrapped to 0
    frame_pulse();
    run_line("R5");                 // offset 1 again
    lrst_n = 1'b0;
    @(negedge clk);
    exp_off = 0;
    frame_pulse();
    run_line("R6");
  endtask

  task automatic t_reserved();
    check(!mode_err, "R10", "flag before reserved", longint'(mode_err), 0);
    mode_a = 1'b1; mode_b = 1'b1;
    run_line("R10");
    check(mode_err, "R10", "flag raised", longint'(mode_err), 1);
    mode_a = 1'b0; mode_b = 1'b0;
    repeat (3) @(negedge clk);
    check(mode_err, "R10", "flag sticky", longint'(mode_err), 1);
  endtask

  task automatic t_gap();
    mode_a = 1'b0; mode_b = 1'b0;
    pix_valid = 1'b1; line_start = 1'b1; pix_data = 16'h1111;
    @(negedge clk);
    check(bus_vld == 8'h01 && col_out == 0, "R7", "gap col0",
          longint'(col_out), 0);
    line_start = 1'b0; pix_data = 16'h2222;
    @(negedge clk);
    check(col_out == 1 && bus_data[DW-1:0] == 16'h2222, "R7", "gap col1",
          longint'(col_out), 1);
    pix_valid = 1'b0;
    @(negedge clk);
    check_idle("R11");
    pix_valid = 1'b1; pix_data = 16'h3333;
    @(negedge clk);
    check(col_out == 2 && bus_data[DW-1:0] == 16'h3333, "R7", "after gap col2",
          longint'(col_out), 2);
    pix_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_spread();
    t_hold();
    t_rotate();
    t_gap();
    t_reserved();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule